// File: doc/BRIEF.md
# Staged Pipeline Control Bundle

This block turns the opcode of a 32-bit instruction in the decode stage into nine discrete control bits. It then carries them down a five-stage in-order pipeline. The bits fall into three groups. The execute group steers the ALU operand source, the ALU operation class and the choice of destination register field. The memory group marks a branch, a load or a store. The write-back group enables the register-file write and picks memory data or the ALU result as the value to write.

All nine bits are captured into the decode/execute register. The execute group is used there and dropped. The execute/memory register keeps only the memory and write-back groups, along with the destination register number chosen in execute. The memory/write-back register keeps only the write-back group and the destination. A hazard unit can ask for a bubble. The whole bundle entering execute then reads as zero, so the slot does nothing in every later stage.

Only register-type ALU operations, word load, word store and branch-on-equal are decoded. Every other opcode gives an all-zero bundle.

Top module: `pipe_ctrl_stager`

## Requirements
- R1: While rst_ni is low, every control output and both destination outputs read 0.
- R2: Opcode 6'h00 (instruction bits [31:26]), one clock after capture, drives ex_reg_dst_o=1, ex_alu_op_o=2'b10 and ex_alu_src_o=0. It later gives wb_reg_write_o=1 and wb_mem_to_reg_o=0, with no memory-group bit set.
- R3: Opcode 6'h23 gives ex_alu_src_o=1 and ex_alu_op_o=2'b00, then mem_read_o=1, then wb_mem_to_reg_o=1 and wb_reg_write_o=1. mem_read_o and mem_write_o are never both 1.
- R4: Opcode 6'h2B gives ex_alu_src_o=1, then mem_write_o=1, and sets no write-back bit.
- R5: Opcode 6'h04 gives ex_alu_op_o=2'b01 with ex_alu_src_o=0, then mem_branch_o=1, and sets no write-back bit.
- R6: Any other opcode gives all-zero control in every stage.
- R7: The destination number is instruction bits [15:11] when the captured register-destination select is 1, and bits [20:16] otherwise. It appears on mem_dest_o one cycle after the execute outputs and on wb_dest_o one cycle after that.
- R8: The memory-group outputs show, one cycle late, the memory bits held in the decode/execute register. The write-back outputs show, one cycle later still, the write-back bits.
- R9: When bubble_i is 1 at a capturing edge, all execute outputs read 0 in the next cycle. The slot then reads as 0 on the memory and write-back outputs in the cycles after that.
- R10: Instructions presented on consecutive cycles move through the stages independently: three different instructions are visible at once in execute, memory and write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word in the decode stage |
| bubble_i | input | 1 | Replace the captured control with zeros |
| ex_reg_dst_o | output | 1 | Execute: use bits [15:11] as the destination |
| ex_alu_op_o | output | 2 | Execute: ALU operation class |
| ex_alu_src_o | output | 1 | Execute: ALU B operand from the immediate |
| mem_branch_o | output | 1 | Memory: branch in this stage |
| mem_read_o | output | 1 | Memory: data read |
| mem_write_o | output | 1 | Memory: data write |
| mem_dest_o | output | 5 | Memory: destination register number |
| wb_mem_to_reg_o | output | 1 | Write-back: select memory data |
| wb_reg_write_o | output | 1 | Write-back: register file write enable |
| wb_dest_o | output | 5 | Write-back: destination register number |

## Verification
The hardest case to reach from the ports is three different instructions occupying execute, memory and write-back in the same cycle. Only that case shows that no group leaks into a neighbouring slot. The stimulus gets there by presenting a register-type operation, a load and a store on consecutive edges, each with different register fields. It then checks all three stages in the cycle after the third edge. A bubbled load gets a similar treatment: its register fields are still captured, so the destination outputs must follow the bits [20:16] path while every control bit stays zero.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_ALU   = 6'h00;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
   localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
   localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;

   typedef struct packed {
      logic       reg_dst;
      logic [1:0] alu_op;
      logic       alu_src;
   } ex_ctl_t;

   typedef struct packed {
      logic branch;
      logic mem_rd;
      logic mem_wr;
   } mem_ctl_t;

   typedef struct packed {
      logic mem_to_reg;
      logic reg_wr;
   } wb_ctl_t;

   typedef struct packed {
      ex_ctl_t  ex;
      mem_ctl_t mem;
      wb_ctl_t  wb;
   } ctl_bundle_t;

   localparam int CTL_W = $bits(ctl_bundle_t);
   localparam int MEM_W = $bits(mem_ctl_t);
   localparam int WB_W  = $bits(wb_ctl_t);

endpackage

// File: rtl/pctl_decoder.sv
module pctl_decoder
   import pctl_pkg::*;
(
   input  logic [OPC_W-1:0] opc_i,
   input  logic             bubble_i,
   output ctl_bundle_t      ctl_o
);

   ctl_bundle_t dec;

   always_comb begin
      dec = '0;
      unique case (opc_i)
         OPC_ALU: begin
            dec.ex.reg_dst = 1'b1;
            dec.ex.alu_op  = 2'b10;
            dec.wb.reg_wr  = 1'b1;
         end
         OPC_LOAD: begin
            dec.ex.alu_src    = 1'b1;
            dec.mem.mem_rd    = 1'b1;
            dec.wb.mem_to_reg = 1'b1;
            dec.wb.reg_wr     = 1'b1;
         end
         OPC_STORE: begin
            dec.ex.alu_src = 1'b1;
            dec.mem.mem_wr = 1'b1;
         end
         OPC_BREQ: begin
            dec.ex.alu_op  = 2'b01;
            dec.mem.branch = 1'b1;
         end
         default: dec = '0;
      endcase
   end

   assign ctl_o = bubble_i ? '0 : dec;

endmodule

// File: rtl/pctl_stage_reg.sv
module pctl_stage_reg #(
   parameter int W         = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("pctl_stage_reg: W must be at least 1");
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o <= '0;
         else         q_o <= d_i;
      end
   end else begin : g_sync
      always_ff @(posedge clk_i) begin
         if (!rst_ni) q_o <= '0;
         else         q_o <= d_i;
      end
   end

endmodule

// File: rtl/pipe_ctrl_stager.sv
module pipe_ctrl_stager
   import pctl_pkg::*;
#(
   parameter int INSTR_W   = 32,
   parameter int OPC_LSB   = 26,
   parameter int REG_IDX_W = 5,
   parameter int RT_LSB    = 16,
   parameter int RD_LSB    = 11,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [INSTR_W-1:0]   instr_i,
   input  logic                 bubble_i,
   output logic                 ex_reg_dst_o,
   output logic [1:0]           ex_alu_op_o,
   output logic                 ex_alu_src_o,
   output logic                 mem_branch_o,
   output logic                 mem_read_o,
   output logic                 mem_write_o,
   output logic [REG_IDX_W-1:0] mem_dest_o,
   output logic                 wb_mem_to_reg_o,
   output logic                 wb_reg_write_o,
   output logic [REG_IDX_W-1:0] wb_dest_o
);

   localparam int IDEX_W  = CTL_W + 2 * REG_IDX_W;
   localparam int EXMEM_W = MEM_W + WB_W + REG_IDX_W;
   localparam int MEMWB_W = WB_W + REG_IDX_W;

   if (OPC_LSB + OPC_W > INSTR_W) begin : g_bad_opc
      $error("pipe_ctrl_stager: opcode field exceeds instruction width");
   end
   if (RT_LSB + REG_IDX_W > INSTR_W || RD_LSB + REG_IDX_W > INSTR_W) begin : g_bad_fld
      $error("pipe_ctrl_stager: register field exceeds instruction width");
   end

   // decode stage
   ctl_bundle_t dec_ctl;

   pctl_decoder u_dec (
      .opc_i    (instr_i[OPC_LSB +: OPC_W]),
      .bubble_i (bubble_i),
      .ctl_o    (dec_ctl)
   );

   // decode/execute register: full bundle plus both candidate fields
   logic [IDEX_W-1:0] idex_d, idex_q;
   ctl_bundle_t           idex_ctl;
   logic [REG_IDX_W-1:0]  idex_rt, idex_rd;

   assign idex_d = {dec_ctl, instr_i[RT_LSB +: REG_IDX_W], instr_i[RD_LSB +: REG_IDX_W]};

   pctl_stage_reg #(.W(IDEX_W), .ASYNC_RST(ASYNC_RST)) u_idex (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (idex_d), .q_o (idex_q)
   );

   assign {idex_ctl, idex_rt, idex_rd} = idex_q;

   // execute stage: destination chosen here, execute group dropped
   logic [REG_IDX_W-1:0] ex_dest;
   always_comb begin
      ex_dest = idex_ctl.ex.reg_dst ? idex_rd : idex_rt;
   end

   assign ex_reg_dst_o = idex_ctl.ex.reg_dst;
   assign ex_alu_op_o  = idex_ctl.ex.alu_op;
   assign ex_alu_src_o = idex_ctl.ex.alu_src;

   // execute/memory register
   logic [EXMEM_W-1:0] exmem_q;
   mem_ctl_t           exmem_mem;
   wb_ctl_t            exmem_wb;
   logic [REG_IDX_W-1:0] exmem_dest;

   pctl_stage_reg #(.W(EXMEM_W), .ASYNC_RST(ASYNC_RST)) u_exmem (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .d_i   ({idex_ctl.mem, idex_ctl.wb, ex_dest}),
      .q_o   (exmem_q)
   );

   assign {exmem_mem, exmem_wb, exmem_dest} = exmem_q;

   assign mem_branch_o = exmem_mem.branch;
   assign mem_read_o   = exmem_mem.mem_rd;
   assign mem_write_o  = exmem_mem.mem_wr;
   assign mem_dest_o   = exmem_dest;

   // memory/write-back register: memory group dropped
   logic [MEMWB_W-1:0] memwb_q;
   wb_ctl_t            memwb_wb;
   logic [REG_IDX_W-1:0] memwb_dest;

   pctl_stage_reg #(.W(MEMWB_W), .ASYNC_RST(ASYNC_RST)) u_memwb (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .d_i   ({exmem_wb, exmem_dest}),
      .q_o   (memwb_q)
   );

   assign {memwb_wb, memwb_dest} = memwb_q;

   assign wb_mem_to_reg_o = memwb_wb.mem_to_reg;
   assign wb_reg_write_o  = memwb_wb.reg_wr;
   assign wb_dest_o       = memwb_dest;

endmodule

// File: rtl/pctl_checker.sv
module pctl_checker
   import pctl_pkg::*;
#(
   parameter int INSTR_W   = 32,
   parameter int OPC_LSB   = 26,
   parameter int REG_IDX_W = 5
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [INSTR_W-1:0]   instr_i,
   input logic                 bubble_i,
   input ctl_bundle_t          idex_ctl,
   input logic [REG_IDX_W-1:0] idex_rt,
   input logic [REG_IDX_W-1:0] idex_rd,
   input logic                 ex_reg_dst_o,
   input logic [1:0]           ex_alu_op_o,
   input logic                 ex_alu_src_o,
   input logic                 mem_branch_o,
   input logic                 mem_read_o,
   input logic                 mem_write_o,
   input logic [REG_IDX_W-1:0] mem_dest_o,
   input logic                 wb_mem_to_reg_o,
   input logic                 wb_reg_write_o,
   input logic [REG_IDX_W-1:0] wb_dest_o
);

   logic [OPC_W-1:0] opc;
   logic             opc_known;
   assign opc       = instr_i[OPC_LSB +: OPC_W];
   assign opc_known = (opc == OPC_ALU) || (opc == OPC_LOAD) ||
                      (opc == OPC_STORE) || (opc == OPC_BREQ);

   assert_bubble_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bubble_i |=> (!ex_reg_dst_o && ex_alu_op_o == 2'b00 && !ex_alu_src_o));

   assert_unknown_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bubble_i && !opc_known) |=> (idex_ctl == '0));

   assert_mem_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ({mem_branch_o, mem_read_o, mem_write_o} == $past(idex_ctl.mem)));

   assert_wb_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ({wb_mem_to_reg_o, wb_reg_write_o} ==
                $past({idex_ctl.wb.mem_to_reg, idex_ctl.wb.reg_wr}, 2)));

   assert_dest_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (mem_dest_o == ($past(ex_reg_dst_o) ? $past(idex_rd) : $past(idex_rt))));

   assert_dest_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (wb_dest_o == $past(mem_dest_o)));

   assert_rd_wr_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mem_read_o && mem_write_o));

endmodule

bind pipe_ctrl_stager pctl_checker #(
   .INSTR_W   (INSTR_W),
   .OPC_LSB   (OPC_LSB),
   .REG_IDX_W (REG_IDX_W)
) u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .instr_i         (instr_i),
   .bubble_i        (bubble_i),
   .idex_ctl        (idex_ctl),
   .idex_rt         (idex_rt),
   .idex_rd         (idex_rd),
   .ex_reg_dst_o    (ex_reg_dst_o),
   .ex_alu_op_o     (ex_alu_op_o),
   .ex_alu_src_o    (ex_alu_src_o),
   .mem_branch_o    (mem_branch_o),
   .mem_read_o      (mem_read_o),
   .mem_write_o     (mem_write_o),
   .mem_dest_o      (mem_dest_o),
   .wb_mem_to_reg_o (wb_mem_to_reg_o),
   .wb_reg_write_o  (wb_reg_write_o),
   .wb_dest_o       (wb_dest_o)
);

// File: tb/pipe_ctrl_stager_test.sv
module pipe_ctrl_stager_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic [31:0] instr = '0;
   logic        bubble = 1'b0;
   logic        ex_reg_dst, ex_alu_src, mem_branch, mem_read, mem_write;
   logic        wb_mem_to_reg, wb_reg_write;
   logic [1:0]  ex_alu_op;
   logic [4:0]  mem_dest, wb_dest;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_ctrl_stager uut (
      .clk_i (clk), .rst_ni (rst_ni), .instr_i (instr), .bubble_i (bubble),
      .ex_reg_dst_o (ex_reg_dst), .ex_alu_op_o (ex_alu_op), .ex_alu_src_o (ex_alu_src),
      .mem_branch_o (mem_branch), .mem_read_o (mem_read), .mem_write_o (mem_write),
      .mem_dest_o (mem_dest), .wb_mem_to_reg_o (wb_mem_to_reg),
      .wb_reg_write_o (wb_reg_write), .wb_dest_o (wb_dest)
   );

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [4:0] rd);
      return {op, 5'd17, rt, rd, 11'h2A5};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int ex_v();  return {ex_reg_dst, ex_alu_op, ex_alu_src}; endfunction
   function automatic int mem_v(); return {mem_branch, mem_read, mem_write};  endfunction
   function automatic int wb_v();  return {wb_mem_to_reg, wb_reg_write};      endfunction

   // one instruction walked through execute, memory and write-back
   task automatic run_one(input string req, input logic [31:0] ins, input logic bub,
                          input int e_ex, input int e_mem, input int e_wb, input int e_dst);
      @(negedge clk); instr = ins; bubble = bub;
      @(posedge clk); #1;
      chk({req, " ex"}, ex_v(), e_ex);
      @(negedge clk); instr = mk(6'h3F, 5'd0, 5'd0); bubble = 1'b0;
      @(posedge clk); #1;
      chk({req, " mem"}, mem_v(), e_mem);
      chk({req, " R7 mem_dest"}, mem_dest, e_dst);
      @(posedge clk); #1;
      chk({req, " R8 wb"}, wb_v(), e_wb);
      chk({req, " R7 wb_dest"}, wb_dest, e_dst);
   endtask

   task automatic t_reset_R1();
      rst_ni = 1'b0; instr = mk(6'h23, 5'd9, 5'd4);
      repeat (2) @(posedge clk); #1;
      chk("R1 ex", ex_v(), 0);
      chk("R1 mem", mem_v(), 0);
      chk("R1 wb", wb_v(), 0);
      chk("R1 dest", {mem_dest, wb_dest}, 0);
      @(negedge clk); rst_ni = 1'b1;
   endtask

   task automatic t_stream_R10();
      @(negedge clk); instr = mk(6'h00, 5'd3, 5'd10); bubble = 1'b0;
      @(negedge clk); instr = mk(6'h23, 5'd11, 5'd20);
      @(negedge clk); instr = mk(6'h2B, 5'd12, 5'd21);
      @(posedge clk); #1;
      chk("R10 ex store", ex_v(), 4'h1);
      chk("R10 mem load", mem_v(), 3'b010);
      chk("R10 mem_dest", mem_dest, 11);
      chk("R10 wb alu", wb_v(), 2'b01);
      chk("R10 wb_dest", wb_dest, 10);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset_R1();
      run_one("R2 alu",     mk(6'h00, 5'd3, 5'd7),  1'b0, 4'hC, 3'b000, 2'b01, 7);
      run_one("R3 load",    mk(6'h23, 5'd9, 5'd4),  1'b0, 4'h1, 3'b010, 2'b11, 9);
      run_one("R4 store",   mk(6'h2B, 5'd5, 5'd6),  1'b0, 4'h1, 3'b001, 2'b00, 5);
      run_one("R5 branch",  mk(6'h04, 5'd2, 5'd1),  1'b0, 4'h2, 3'b100, 2'b00, 2);
      run_one("R6 unknown", mk(6'h08, 5'd1, 5'd30), 1'b0, 4'h0, 3'b000, 2'b00, 1);
      run_one("R9 bubble",  mk(6'h23, 5'd9, 5'd4),  1'b1, 4'h0, 3'b000, 2'b00, 9);
      run_one("R9 bubble alu", mk(6'h00, 5'd3, 5'd7), 1'b1, 4'h0, 3'b000, 2'b00, 3);
      t_stream_R10();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule